// File: doc/BRIEF.md
# Clock-Enable Configuration Slave on a Two-Wire Bus

This block is a target on a two-wire serial bus (SCL clock, SDA open-drain data). It keeps a small bank of clock-enable bytes that a bus controller can program and read back. One bit in the bank enables one clock output. The block samples both bus lines with the system clock, so the system clock must run many times faster than SCL. It finds START and STOP conditions, accepts only its own 7-bit address, and pulls SDA low to acknowledge bytes. It also shifts stored bytes out when the controller reads.

A write carries two filler bytes after the address, a command byte and then a count byte. The block acknowledges both and then discards them. The bytes that follow fill the bank from byte 0 upward until STOP. A read returns the bank from byte 0 upward straight after the address, with no count byte. The whole bank is also presented as a flat parallel vector, so the clock gates can use it directly.

The bus has no valid/ready handshake: the controller sets the pace, and the block never stretches SCL. SDA is modelled as a pull-down enable. The line reads low whenever that enable is high.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset every bank byte is 8'hFF, so `cfg_o` is all ones, and `sda_oe_o` is low, which leaves SDA released.
- R2: The address byte 8'hD2 (address 7'b1101001, R/W bit 0) is acknowledged. An address byte whose upper seven bits differ is not acknowledged, and the block then ignores every later byte until the next START or STOP.
- R3: In a write, the first two bytes after the address are acknowledged, and their contents change no bank byte.
- R4: Write data bytes land in bank byte 0, 1, 2 in turn. Bank byte k appears on `cfg_o[8k+7:8k]`, and the first bit on the bus is the MSB.
- R5: A STOP after any complete byte ends the write. Bytes already received stay stored, and the bytes not written keep their earlier values.
- R6: After the address byte 8'hD3 (R/W bit 1), the block drives bank byte 0, 1, 2 in turn, MSB first, with no count byte ahead of them.
- R7: During a read, a NACK from the controller after a byte ends transmission, and SDA stays released until the next START.
- R8: A repeated START at any point returns the block to address reception and resets the byte pointer to byte 0, for both writing and reading.
- R9: Write data bytes past the last bank byte are acknowledged but discarded. Read bytes past the last bank byte return 8'hFF.
- R10: The block pulls SDA low during the acknowledge clock after each byte it accepts: the matching address byte, the two filler bytes and every data byte. It changes its SDA drive only while SCL is low, or when it releases the line at START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND result) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | NBYTES*8 | Bank contents, byte k on bits [8k+7:8k] |

## Verification
The hardest case to reach from the ports is a repeated START in the middle of a write that has already stored data. The pointer must then go back to byte 0 without disturbing the byte already written. The stimulus writes one byte, issues a repeated START with no STOP, writes a different value, and then uses another repeated START into a read so that the reset pointer shows on the bus. Address mismatch and writes or reads past the end of the bank are reached by sending extra bytes, and the bench then checks that nothing is acknowledged or stored where it should not be.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  typedef enum logic [2:0] {
    LS_IDLE,
    LS_RX,
    LS_RACK,
    LS_TX,
    LS_TACK
  } link_state_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_CMD,
    BK_CNT,
    BK_DATA
  } byte_kind_t;
endpackage

// File: rtl/clkcfg_bus_sync.sv
module clkcfg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA moves while SCL holds high on both samples
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank #(
  parameter int NBYTES = 3,
  parameter int PW     = 2
) (
  input  logic                rst_n,
  input  logic                clk,
  input  logic                wr_en,
  input  logic [PW-1:0]       wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [PW-1:0]       rd_addr,
  output logic [7:0]          rd_data,
  output logic [NBYTES*8-1:0] cfg_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= 8'hFF;
      else if (wr_en && wr_addr == PW'(g))      q <= wr_data;
    end
    assign cfg_o[g*8 +: 8] = q;
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NBYTES; i++) begin
      if (rd_addr == PW'(i)) rd_data = cfg_o[i*8 +: 8];
    end
  end
endmodule

// File: rtl/clkcfg_link.sv
module clkcfg_link
  import clkcfg_pkg::*;
#(
  parameter int         NBYTES = 3,
  parameter int         PW     = 2,
  parameter logic [6:0] ADDR   = 7'b1101001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [PW-1:0] rd_addr,
  output logic          wr_en,
  output logic [PW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_pull
);
  localparam logic [PW-1:0] LAST = PW'(NBYTES);

  link_state_t   state;
  byte_kind_t    kind;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [7:0]    tx_sh;
  logic          rw;
  logic          nack;
  logic [PW-1:0] ptr;

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LS_IDLE;
      kind     <= BK_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      tx_sh    <= '0;
      rw       <= 1'b0;
      nack     <= 1'b0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= LS_RX;
        kind     <= BK_ADDR;
        bitcnt   <= '0;
        ptr      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= LS_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          LS_IDLE: ;
          LS_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              unique case (kind)
                BK_ADDR: begin
                  if (shreg[7:1] == ADDR) begin
                    rw       <= shreg[0];
                    kind     <= BK_CMD;
                    state    <= LS_RACK;
                    sda_pull <= 1'b1;
                  end else begin
                    state <= LS_IDLE;
                  end
                end
                BK_CMD: begin
                  kind     <= BK_CNT;
                  state    <= LS_RACK;
                  sda_pull <= 1'b1;
                end
                BK_CNT: begin
                  kind     <= BK_DATA;
                  state    <= LS_RACK;
                  sda_pull <= 1'b1;
                end
                BK_DATA: begin
                  state    <= LS_RACK;
                  sda_pull <= 1'b1;
                  wr_en    <= (ptr < LAST);
                  wr_addr  <= ptr;
                  wr_data  <= shreg;
                  if (ptr < LAST) ptr <= ptr + 1'b1;
                end
              endcase
            end
          end
          LS_RACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                state    <= LS_TX;
                tx_sh    <= rd_data;
                sda_pull <= ~rd_data[7];
                if (ptr < LAST) ptr <= ptr + 1'b1;
              end else begin
                state    <= LS_RX;
                sda_pull <= 1'b0;
              end
            end
          end
          LS_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                state    <= LS_TACK;
                sda_pull <= 1'b0;
              end else begin
                tx_sh    <= {tx_sh[6:0], 1'b0};
                sda_pull <= ~tx_sh[6];
                bitcnt   <= bitcnt + 4'd1;
              end
            end
          end
          LS_TACK: begin
            if (scl_rise) nack <= sda_s;
            if (scl_fall) begin
              bitcnt <= '0;
              if (nack) begin
                state <= LS_IDLE;
              end else begin
                state    <= LS_TX;
                tx_sh    <= rd_data;
                sda_pull <= ~rd_data[7];
                if (ptr < LAST) ptr <= ptr + 1'b1;
              end
            end
          end
          default: state <= LS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter int         NBYTES      = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR        = 7'b1101001
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  output logic [NBYTES*8-1:0] cfg_o
);
  localparam int PW = $clog2(NBYTES + 1);

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en;
  logic [PW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  clkcfg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  clkcfg_link #(.NBYTES(NBYTES), .PW(PW), .ADDR(ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_pull(sda_oe_o)
  );

  clkcfg_regbank #(.NBYTES(NBYTES), .PW(PW)) u_bank (
    .rst_n(rst_n), .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cfg_o(cfg_o)
  );
endmodule

// File: rtl/clkcfg_i2c_slave_chk.sv
module clkcfg_i2c_slave_chk #(
  parameter int NBYTES = 3,
  parameter int PW     = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sda_oe_o,
  input logic                scl_s,
  input logic                start_det,
  input logic                stop_det,
  input logic                wr_en,
  input logic [PW-1:0]       wr_addr,
  input logic [NBYTES*8-1:0] cfg_o
);
  // R4
  cfg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(wr_en));

  // R9
  wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < PW'(NBYTES)));

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe_o);

  // R10
  oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_slave_chk #(.NBYTES(NBYTES), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .scl_s(scl_s),
  .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en),
  .wr_addr(wr_addr), .cfg_o(cfg_o)
);

// File: tb/clkcfg_i2c_slave_tb.sv
module clkcfg_i2c_slave_tb;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [23:0] cfg;
  wire  sda_line = m_sda & ~sda_oe;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  clkcfg_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq();
      m_scl = 1'b1; wq(); wq();
      m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit give_nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      b[i] = sda_line;
      wq();
      m_scl = 1'b0; wq();
    end
    m_sda = give_nack; wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  task automatic write_seq(input logic [7:0] d [], input string req);
    bit a;
    send_byte(8'hD2, a);  chk(a, "R2 address D2 ack", a, 1);
    send_byte(8'h5A, a);  chk(a, "R3 command byte ack", a, 1);
    send_byte(8'h03, a);  chk(a, "R3 count byte ack", a, 1);
    foreach (d[i]) begin
      send_byte(d[i], a); chk(a, req, a, 1);
    end
  endtask

  task automatic t_reset();
    chk(cfg == 24'hFFFFFF, "R1 cfg reset", cfg, 24'hFFFFFF);
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
  endtask

  task automatic t_full_write();
    bus_start();
    write_seq('{8'hA1, 8'hB2, 8'hC3}, "R10 data ack");
    bus_stop();
    chk(cfg == 24'hC3B2A1, "R4 R3 full write", cfg, 24'hC3B2A1);
  endtask

  task automatic t_partial_write();
    bus_start();
    write_seq('{}, "R5");
    bus_stop();
    chk(cfg == 24'hC3B2A1, "R3 fillers only no effect", cfg, 24'hC3B2A1);
    bus_start();
    write_seq('{8'h0F}, "R10 data ack");
    bus_stop();
    chk(cfg == 24'hC3B20F, "R5 partial write", cfg, 24'hC3B20F);
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a); chk(a, "R6 address D3 ack", a, 1);
    recv_byte(1'b0, b);  chk(b == 8'h0F, "R6 read byte0", b, 8'h0F);
    recv_byte(1'b0, b);  chk(b == 8'hB2, "R6 read byte1", b, 8'hB2);
    recv_byte(1'b1, b);  chk(b == 8'hC3, "R6 read byte2", b, 8'hC3);
    repeat (4 * Q) @(negedge clk);
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_overrun();
    bit a;
    logic [7:0] b;
    bus_start();
    write_seq('{8'h11, 8'h22, 8'h33, 8'h44}, "R9 ack incl past end");
    bus_stop();
    chk(cfg == 24'h332211, "R9 overrun discarded", cfg, 24'h332211);
    bus_start();
    send_byte(8'hD3, a); chk(a, "R6 address D3 ack", a, 1);
    recv_byte(1'b0, b);  chk(b == 8'h11, "R9 read byte0", b, 8'h11);
    recv_byte(1'b0, b);  chk(b == 8'h22, "R9 read byte1", b, 8'h22);
    recv_byte(1'b0, b);  chk(b == 8'h33, "R9 read byte2", b, 8'h33);
    recv_byte(1'b1, b);  chk(b == 8'hFF, "R9 read past end", b, 8'hFF);
    bus_stop();
  endtask

  task automatic t_mismatch();
    bit a;
    bus_start();
    send_byte(8'hA4, a); chk(!a, "R2 foreign address nack", a, 0);
    send_byte(8'h00, a); chk(!a, "R2 ignored after mismatch", a, 0);
    send_byte(8'h00, a); chk(!a, "R2 ignored after mismatch", a, 0);
    bus_stop();
    chk(cfg == 24'h332211, "R2 cfg untouched", cfg, 24'h332211);
  endtask

  task automatic t_restart();
    bit a;
    logic [7:0] b;
    bus_start();
    write_seq('{8'h55}, "R10 data ack");
    bus_start();
    write_seq('{8'h66}, "R8 data ack after restart");
    chk(cfg == 24'h332266, "R8 pointer reset on write", cfg, 24'h332266);
    bus_start();
    send_byte(8'hD3, a); chk(a, "R8 read address ack", a, 1);
    recv_byte(1'b1, b);  chk(b == 8'h66, "R8 read from byte0", b, 8'h66);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_full_write();
    t_partial_write();
    t_read();
    t_overrun();
    t_mismatch();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule